// File: doc/BRIEF.md
# Power Converter Fault Protection Sequencer

This block is the digital supervisor of a multiphase buck controller. Analog comparators outside it report over-current, over-voltage, the two supply lockout thresholds, a discharged soft-start capacitor, the delay comparator and power-good. From these it decides when the converter must stop. It then drives the protection outputs: the fault latch, the error-amplifier pull-down that also inhibits switching, the soft-start discharge enable, and the over-voltage signal with its share-line override toward the phase ICs.

Over-current is handled in two ways, depending on whether power-good has been reached. Before power-good, a counter advanced by the switching-cycle tick gives the event a grace period. The number of cycles grows with the selected switching frequency, so the grace time stays about the same. After power-good, the event instead enables the discharge of the external soft-start capacitor, and the delay comparator decides when to trip. An over-current fault clears itself once the capacitor is empty, and the converter restarts (hiccup). An over-voltage fault is sticky and needs a supply lockout cycle to clear. The block also picks which reference the over-voltage comparator uses in each operating phase.

Top module: `pwr_fault_seq`

## Requirements
- R1: After reset, and while the supply is locked out, fault_o, ovp_o and ea_pull_o are 1. They all go to 0 one clock after uv_rise_i is sampled high with uv_fall_i low.
- R2: uv_fall_i sampled high sets fault_o and ovp_o on the next clock. It overrides every other input, including a uv_rise_i in the same cycle.
- R3: While power-good is low and no fault is latched, fault_o rises one clock after the clock edge that samples the N-th consecutive sw_tick_i with oc_i high. N = 8 << freq_sel_i, giving 8, 16, 32 and 64 for codes 0 to 3.
- R4: A sw_tick_i sampled with oc_i low returns the over-current count to zero. Clock cycles without a tick leave the count unchanged.
- R5: While fault_o is 1 and the supply is valid, ss_low_i sampled high clears fault_o on the next clock. The over-current count then starts again from zero, so a persisting over-current repeats the sequence (hiccup).
- R6: While pgood_i is 1 and no fault is latched, oc_i raises ss_dis_o on the next clock. oc_i together with dly_trip_i sets fault_o on the next clock.
- R7: ea_pull_o is 1 exactly when fault_o or ovp_o is 1. ss_dis_o is 1 whenever fault_o is 1.
- R8: pgood_o follows pgood_i in the same cycle, and is forced to 0 while fault_o or ovp_o is 1.
- R9: ov_i sets ovp_o and share_hi_o on the next clock. They stay set through ss_low_i and through uv_rise_i while the supply is valid. Only a lockout (uv_fall_i) followed by uv_rise_i clears them.
- R10: One clock after sampling, ovref_sel_o selects the over-voltage reference: 0 (boot level) when boot_mode_i is 1, otherwise 2 (DAC) when pgood_i is 1, otherwise 1 (last VID).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tick_i | input | 1 | One-cycle pulse per switching period |
| freq_sel_i | input | SEL_W | Switching-frequency code, scales the delay count |
| oc_i | input | 1 | Over-current comparator output |
| ov_i | input | 1 | Over-voltage comparator output |
| uv_rise_i | input | 1 | Supply above the rising lockout threshold |
| uv_fall_i | input | 1 | Supply below the falling lockout threshold |
| ss_low_i | input | 1 | Soft-start capacitor below the restart level |
| dly_trip_i | input | 1 | Delay comparator tripped (capacitor below its offset) |
| pgood_i | input | 1 | Power-good from the output monitor |
| boot_mode_i | input | 1 | Converter is in boot mode |
| fault_o | output | 1 | Fault latch state |
| ea_pull_o | output | 1 | Error-amplifier pull-down and switching inhibit |
| ss_dis_o | output | 1 | Soft-start capacitor discharge enable |
| ovp_o | output | 1 | Over-voltage signal to the system |
| share_hi_o | output | 1 | Forces the phase-IC share line high |
| pgood_o | output | 1 | Gated power-good |
| ovref_sel_o | output | 2 | Over-voltage reference select |

## Verification
Every latch output (fault_o, ovp_o, share_hi_o, ea_pull_o, ss_dis_o, ovref_sel_o) changes one clock after its cause is sampled. pgood_o is combinational and changes in the same cycle. The bench drives inputs just after the falling edge and compares a behavioural reference model with the outputs on every falling edge. By then exactly one rising edge has passed since the inputs were applied. Directed checks are placed at the cycle where R3's N-th tick takes effect, one tick earlier, and at the clear, trip and lockout points. A pseudo-random phase then covers the rest against the model.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [1:0] {
        REF_BOOT = 2'd0,
        REF_VID  = 2'd1,
        REF_DAC  = 2'd2
    } ovref_e;

    typedef struct packed {
        logic uv_ok;
        logic fault;
        logic ocd;
    } core_st_t;

    typedef struct packed {
        logic   ov;
        ovref_e sel;
    } ovl_st_t;

endpackage

// File: rtl/fsq_oc_delay.sv
module fsq_oc_delay #(
    parameter int DLY_BASE = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             oc_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);
    localparam int NSEL    = 1 << SEL_W;
    localparam int LIM_MAX = DLY_BASE << (NSEL - 1);
    localparam int CW      = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dly_st_t;

    logic [CW-1:0] lim_tab [NSEL];

    // one terminal count per frequency code: higher frequency, more cycles
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = CW'(DLY_BASE << g);
    end

    dly_st_t       st_d, st_q;
    logic [CW-1:0] nxt;
    logic          expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        nxt    = st_q.cnt + 1'b1;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (oc_i) begin
                if (nxt >= lim_tab[sel_i]) begin
                    expire   = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = nxt;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire_o = expire;

endmodule

// File: rtl/fsq_ov_latch.sv
module fsq_ov_latch
    import fsq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   force_i,
    input  logic   clear_i,
    input  logic   ov_i,
    input  logic   boot_i,
    input  logic   pgood_i,
    output logic   ov_o,
    output ovref_e ref_o
);
    ovl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_i)      st_d.ov = 1'b1;
        else if (clear_i) st_d.ov = 1'b0;
        else              st_d.ov = st_q.ov | ov_i;

        if (boot_i)       st_d.sel = REF_BOOT;
        else if (pgood_i) st_d.sel = REF_DAC;
        else              st_d.sel = REF_VID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ov  <= 1'b1;
            st_q.sel <= REF_BOOT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ov_o  = st_q.ov;
    assign ref_o = st_q.sel;

endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq
    import fsq_pkg::*;
#(
    parameter int DLY_BASE = 8,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_tick_i,
    input  logic [SEL_W-1:0] freq_sel_i,
    input  logic             oc_i,
    input  logic             ov_i,
    input  logic             uv_rise_i,
    input  logic             uv_fall_i,
    input  logic             ss_low_i,
    input  logic             dly_trip_i,
    input  logic             pgood_i,
    input  logic             boot_mode_i,
    output logic             fault_o,
    output logic             ea_pull_o,
    output logic             ss_dis_o,
    output logic             ovp_o,
    output logic             share_hi_o,
    output logic             pgood_o,
    output logic [1:0]       ovref_sel_o
);
    core_st_t st_d, st_q;
    logic     uv_ok_w;
    logic     fault_w;
    logic     cnt_clr;
    logic     oc_expire;
    logic     ovl_force;
    logic     ovl_clear;
    logic     ov_lat;
    ovref_e   ref_sel;

    assign uv_ok_w = st_q.uv_ok;
    assign fault_w = st_q.fault;

    // counter only runs in the pre-power-good, fault-free, supply-valid phase
    assign cnt_clr   = uv_fall_i | ~uv_ok_w | fault_w | pgood_i;
    assign ovl_force = uv_fall_i | (~uv_ok_w & ~uv_rise_i);
    assign ovl_clear = ~uv_fall_i & ~uv_ok_w & uv_rise_i;

    fsq_oc_delay #(
        .DLY_BASE (DLY_BASE),
        .SEL_W    (SEL_W)
    ) i_oc_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .tick_i   (sw_tick_i),
        .oc_i     (oc_i),
        .sel_i    (freq_sel_i),
        .expire_o (oc_expire)
    );

    fsq_ov_latch i_ov_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .force_i (ovl_force),
        .clear_i (ovl_clear),
        .ov_i    (ov_i),
        .boot_i  (boot_mode_i),
        .pgood_i (pgood_i),
        .ov_o    (ov_lat),
        .ref_o   (ref_sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ocd = 1'b0;
        if (uv_fall_i) begin
            st_d.uv_ok = 1'b0;
            st_d.fault = 1'b1;
        end else if (!uv_ok_w) begin
            st_d.uv_ok = uv_rise_i;
            st_d.fault = ~uv_rise_i;
        end else if (fault_w) begin
            st_d.fault = ~ss_low_i;
        end else if (pgood_i) begin
            st_d.ocd = oc_i;
            if (oc_i && dly_trip_i) st_d.fault = 1'b1;
        end else if (oc_expire) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.uv_ok <= 1'b0;
            st_q.fault <= 1'b1;
            st_q.ocd   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o     = fault_w;
    assign ovp_o       = ov_lat;
    assign share_hi_o  = ov_lat;
    assign ea_pull_o   = fault_w | ov_lat;
    assign ss_dis_o    = fault_w | st_q.ocd;
    assign pgood_o     = pgood_i & ~fault_w & ~ov_lat;
    assign ovref_sel_o = ref_sel;

endmodule

// File: rtl/pwr_fault_seq_chk.sv
module pwr_fault_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uv_ok,
    input logic       oc_i,
    input logic       ov_i,
    input logic       uv_rise_i,
    input logic       uv_fall_i,
    input logic       ss_low_i,
    input logic       dly_trip_i,
    input logic       pgood_i,
    input logic       boot_mode_i,
    input logic       fault_o,
    input logic       ea_pull_o,
    input logic       ss_dis_o,
    input logic       ovp_o,
    input logic       pgood_o,
    input logic [1:0] ovref_sel_o
);
    AST_UVLO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv_ok && !uv_rise_i) |=> fault_o); // R1
    AST_UVLO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_fall_i |=> (fault_o && ovp_o)); // R2
    AST_FAULT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_ok && fault_o && ss_low_i && !uv_fall_i) |=> !fault_o); // R5
    AST_PG_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_ok && !fault_o && pgood_i && oc_i && dly_trip_i && !uv_fall_i) |=> fault_o); // R6
    AST_FAULT_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (ea_pull_o && ss_dis_o)); // R7
    AST_PG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o || ovp_o) |-> !pgood_o); // R8
    AST_OV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_i && !ovp_o) |=> ovp_o); // R9
    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_o && uv_ok && !uv_fall_i) |=> ovp_o); // R9
    AST_REF_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        boot_mode_i |=> (ovref_sel_o == 2'd0)); // R10
endmodule

bind pwr_fault_seq pwr_fault_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_ok       (uv_ok_w),
    .oc_i        (oc_i),
    .ov_i        (ov_i),
    .uv_rise_i   (uv_rise_i),
    .uv_fall_i   (uv_fall_i),
    .ss_low_i    (ss_low_i),
    .dly_trip_i  (dly_trip_i),
    .pgood_i     (pgood_i),
    .boot_mode_i (boot_mode_i),
    .fault_o     (fault_o),
    .ea_pull_o   (ea_pull_o),
    .ss_dis_o    (ss_dis_o),
    .ovp_o       (ovp_o),
    .pgood_o     (pgood_o),
    .ovref_sel_o (ovref_sel_o)
);

// File: tb/test_pwr_fault_seq.sv
module test_pwr_fault_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_tick = 1'b0;
    logic [1:0] freq_sel = 2'd0;
    logic       oc = 1'b0, ov = 1'b0, uv_rise = 1'b0, uv_fall = 1'b0;
    logic       ss_low = 1'b0, dly_trip = 1'b0, pgood = 1'b0, boot = 1'b0;
    logic       fault_o, ea_pull_o, ss_dis_o, ovp_o, share_hi_o, pgood_o;
    logic [1:0] ovref_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit m_uv, m_fault, m_ov, m_ocd;
    int m_cnt;
    int m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_fault_seq i_pwr_fault_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_tick_i   (sw_tick),
        .freq_sel_i  (freq_sel),
        .oc_i        (oc),
        .ov_i        (ov),
        .uv_rise_i   (uv_rise),
        .uv_fall_i   (uv_fall),
        .ss_low_i    (ss_low),
        .dly_trip_i  (dly_trip),
        .pgood_i     (pgood),
        .boot_mode_i (boot),
        .fault_o     (fault_o),
        .ea_pull_o   (ea_pull_o),
        .ss_dis_o    (ss_dis_o),
        .ovp_o       (ovp_o),
        .share_hi_o  (share_hi_o),
        .pgood_o     (pgood_o),
        .ovref_sel_o (ovref_sel_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_uv = 0; m_fault = 1; m_ov = 1; m_ocd = 0; m_cnt = 0; m_sel = 0;
        end else begin
            int lim;
            lim = 8 << freq_sel;
            m_ocd = 0;
            if (uv_fall) begin
                m_uv = 0; m_fault = 1; m_ov = 1; m_cnt = 0;
            end else if (!m_uv) begin
                m_cnt = 0;
                if (uv_rise) begin m_uv = 1; m_fault = 0; m_ov = 0; end
            end else begin
                if (ov) m_ov = 1;
                if (m_fault) begin
                    m_cnt = 0;
                    if (ss_low) m_fault = 0;
                end else if (pgood) begin
                    m_cnt = 0;
                    m_ocd = oc;
                    if (oc && dly_trip) m_fault = 1;
                end else if (sw_tick) begin
                    if (!oc) m_cnt = 0;
                    else if (m_cnt + 1 >= lim) begin m_fault = 1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            end
            m_sel = boot ? 0 : (pgood ? 2 : 1);
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(fault_o,     m_fault,                    "R3 fault_o vs model");
            chk(ovp_o,       m_ov,                       "R9 ovp_o vs model");
            chk(share_hi_o,  m_ov,                       "R9 share_hi_o vs model");
            chk(ea_pull_o,   m_fault | m_ov,             "R7 ea_pull_o vs model");
            chk(ss_dis_o,    m_fault | m_ocd,            "R6 ss_dis_o vs model");
            chk(pgood_o,     pgood & !m_fault & !m_ov,   "R8 pgood_o vs model");
            chk(ovref_sel_o, m_sel,                      "R10 ovref_sel_o vs model");
        end
    end

    task automatic nx();
        @(negedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            nx(); sw_tick = 1'b1;
            nx(); sw_tick = 1'b0;
            nx();
            nx();
        end
    endtask

    task automatic clear_fault();
        ss_low = 1'b1; nx(); ss_low = 1'b0; nx();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fault_o, 1, "R1 reset fault");
        chk(ovp_o, 1, "R1 reset ovp");
        chk(ea_pull_o, 1, "R1 reset ea_pull");
        #1 rst_n = 1'b1;
        repeat (5) nx();
        chk(fault_o, 1, "R1 held until rising threshold");
        uv_rise = 1'b1; nx(); uv_rise = 1'b0; nx();
        chk(fault_o, 0, "R1 fault released");
        chk(ovp_o, 0, "R1 ovp released");

        // soft-start delay at code 0 (8 ticks)
        freq_sel = 2'd0; oc = 1'b1;
        ticks(7);
        chk(fault_o, 0, "R3 no fault before count");
        ticks(1);
        chk(fault_o, 1, "R3 fault at 8 ticks");
        chk(ss_dis_o, 1, "R7 discharge while faulted");

        clear_fault();
        chk(fault_o, 0, "R5 cleared by ss_low");
        ticks(8);
        chk(fault_o, 1, "R5 hiccup repeat");
        clear_fault();

        // interruption resets the count
        ticks(5);
        oc = 1'b0; ticks(1); oc = 1'b1;
        ticks(7);
        chk(fault_o, 0, "R4 count restarted");
        ticks(1);
        chk(fault_o, 1, "R4 fault after fresh count");
        clear_fault();

        // code 2 (32 ticks)
        freq_sel = 2'd2;
        ticks(31);
        chk(fault_o, 0, "R3 code 2 before count");
        ticks(1);
        chk(fault_o, 1, "R3 code 2 at 32 ticks");

        // after power-good
        pgood = 1'b1;
        clear_fault();
        nx();
        chk(ss_dis_o, 1, "R6 discharge on oc after pgood");
        chk(fault_o, 0, "R6 no fault before trip");
        dly_trip = 1'b1; nx(); dly_trip = 1'b0; nx();
        chk(fault_o, 1, "R6 fault on delay trip");
        chk(pgood_o, 0, "R8 pgood gated by fault");
        oc = 1'b0;
        clear_fault();
        chk(fault_o, 0, "R5 cleared after pgood trip");
        chk(pgood_o, 1, "R8 pgood passes");

        // reference select
        chk(ovref_sel_o, 2, "R10 DAC after soft start");
        boot = 1'b1; nx(); nx();
        chk(ovref_sel_o, 0, "R10 boot reference");
        boot = 1'b0; pgood = 1'b0; nx(); nx();
        chk(ovref_sel_o, 1, "R10 VID during startup");

        // over-voltage latch
        ov = 1'b1; nx(); ov = 1'b0; nx();
        chk(ovp_o, 1, "R9 ovp set");
        chk(share_hi_o, 1, "R9 share line high");
        chk(ea_pull_o, 1, "R7 ea pull on ovp");
        chk(fault_o, 0, "R9 fault latch untouched");
        clear_fault();
        chk(ovp_o, 1, "R9 ss_low ignored");
        uv_rise = 1'b1; nx(); uv_rise = 1'b0; nx();
        chk(ovp_o, 1, "R9 rise without lockout ignored");

        // lockout
        uv_fall = 1'b1; nx(); uv_fall = 1'b0; nx();
        chk(fault_o, 1, "R2 lockout sets fault");
        chk(ovp_o, 1, "R2 lockout sets ovp");
        uv_fall = 1'b1; uv_rise = 1'b1; nx(); uv_fall = 1'b0; uv_rise = 1'b0; nx();
        chk(fault_o, 1, "R2 fall beats rise");
        uv_rise = 1'b1; nx(); uv_rise = 1'b0; nx();
        chk(ovp_o, 0, "R9 cleared by power cycle");
        chk(fault_o, 0, "R1 released after power cycle");

        // pseudo-random phase against the model
        for (int i = 0; i < 3000; i++) begin
            nx();
            oc       = ($urandom % 4) != 0;
            sw_tick  = ($urandom % 3) == 0;
            ss_low   = ($urandom % 8) == 0;
            dly_trip = ($urandom % 6) == 0;
            ov       = ($urandom % 300) == 0;
            uv_fall  = ($urandom % 400) == 0;
            uv_rise  = ($urandom % 10) == 0;
            if (($urandom % 40) == 0) pgood = ~pgood;
            if (($urandom % 50) == 0) boot = ~boot;
            if (($urandom % 200) == 0) freq_sel = 2'($urandom % 4);
        end
        nx();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule